// File: doc/BRIEF.md
# SPI Real-Time Clock Register File

This block is the device side of a serial real-time clock. A host reaches it over a four-wire SPI link with an active-high chip enable. The first byte of every frame is an address. Its top bit picks write or read, and its low seven bits pick a register. Each later byte in the same frame reads or writes the next register up, so one frame can cover the whole seven-byte time set. Dropping the chip enable ends the frame.

The time registers hold packed BCD. A one-cycle `tick` pulse advances them by one second, with carries through minutes, hours, weekday, date, month and year. The hour counter runs in either 24-hour or 12-hour mode. The date counter knows the length of each month and handles leap years. When a read frame starts, the time registers are copied into a snapshot, so a tick during a burst read cannot give a torn value.

A write-protect flag in the control register blocks writes to every register except the control register. The flag is sampled when a frame opens, so clearing it takes effect only from the next frame. Alarm and trickle storage and a small user RAM window can be read and written but drive nothing. SCK, MOSI and the chip enable are sampled by the system clock. Each SCK level must therefore last at least two system clocks.

Top module: `spi_rtc_regfile`

## Requirements
- R1: In the address byte, bit 7 = 1 makes the frame a write frame and bit 7 = 0 makes it a read frame; bits 6:0 are the start register. Data bytes sent in a read frame change nothing. Bytes go MSB first: MOSI is captured when SCK falls, and MISO changes when SCK rises.
- R2: Within one frame, each later data byte reaches the next address up (modulo 128). A low chip enable ends the frame, and the next frame starts again with an address byte.
- R3: Register map:
  - 0x00 to 0x06: seconds, minutes, hours, weekday, date, month and year, in BCD.
  - 0x07 to 0x0E: eight alarm storage bytes.
  - 0x0F: control.
  - 0x10: status, which reads 0x00 and ignores writes.
  - 0x11: trickle storage.
- R4: Control bit 6 is write protect. While it is set, writes to any register other than 0x0F are dropped. Writes to 0x0F are always accepted.
- R5: Write protect is sampled when the chip enable rises. Clearing it inside a frame leaves the rest of that frame protected.
- R6: Seconds and minutes count in BCD and wrap from 0x59 to 0x00, carrying into the next field.
- R7: With hour bit 6 = 0 (24-hour mode), hours wrap from 0x23 to 0x00 and carry into the day.
- R8: With hour bit 6 = 1 (12-hour mode), bit 5 is PM and bits 4:0 run from 01 to 12 in BCD. The sequence is 11→12, which toggles PM, then 12→01. The day advances only on 11 PM → 12 AM.
- R9: On a day carry:
  - Weekday wraps 7→1.
  - Date wraps to 01 after 28/29 for February (leap when the BCD year is divisible by 4), after 30 for April, June, September and November, and after 31 for the other months.
  - Month wraps 0x12→0x01 and carries into the year.
  - Year wraps 0x99→0x00.
- R10: Reads of 0x00 to 0x06 return a snapshot taken when the frame's chip enable rose. A tick during the frame does not change the bytes read in that frame.
- R11: A user RAM of RAM_BYTES bytes sits at 0x20 upward. Every other address outside the map reads 0x00 and ignores writes.
- R12: While the chip enable is low, `miso` and `miso_oe` are both 0.
- R13: After reset:
  - Time is 00:00:00, weekday 01, date 01, month 01, year 00 (24-hour mode).
  - Control is 0x40.
  - Alarms, trickle and RAM are 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip enable, active high; frames the transfer |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data from the host |
| tick | input | 1 | One-cycle pulse that advances time by one second |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | High while `miso` is driven |

## Verification
On every cycle, the assertions check the following:
- the MISO lines stay quiet with the chip enable low;
- frame state clears between frames;
- a completed address byte starts the data phase;
- the sampled write-protect flag and the read snapshot hold steady for the length of a frame;
- a protected write leaves the trickle byte alone;
- a tick at 59 seconds wraps to zero.

The bench scenarios cover what needs a whole transaction to see:
- burst writes and reads across the time, alarm and RAM windows;
- each calendar rollover, including leap and non-leap February, year 99, and both 12-hour crossings;
- the per-frame latching of write protect;
- a tick landing in the middle of a burst read.

// File: rtl/spi_rtc_regfile.sv
module spi_rtc_regfile #(
  parameter int RAM_BYTES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sck,
  input  logic mosi,
  input  logic tick,
  output logic miso,
  output logic miso_oe
);
  localparam int RAM_AW = (RAM_BYTES > 1) ? $clog2(RAM_BYTES) : 1;
  localparam logic [6:0] CTRL_A = 7'h0F;
  localparam logic [6:0] STAT_A = 7'h10;
  localparam logic [6:0] TRK_A  = 7'h11;
  localparam logic [6:0] RAM_A  = 7'h20;
  localparam logic [6:0] RAM_E  = 7'(32'(RAM_A) + RAM_BYTES);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'h9) ? {v[7:4] + 4'h1, 4'h0} : v + 8'h01;
  endfunction

  logic cs_q, sck_q;
  logic have_addr, wr_mode, wp_frame;
  logic [2:0] bit_cnt;
  logic [6:0] addr;
  logic [7:0] shin, shout, ctrl, trk, rd;
  logic [6:0][7:0] tm, tm_n, snap;
  logic [7:0][7:0] alm;
  logic [RAM_BYTES-1:0][7:0] ram;

  wire frame_start = cs & ~cs_q;
  wire sck_rise    = cs & sck & ~sck_q;
  wire sck_fall    = cs & ~sck & sck_q;
  wire byte_done   = sck_fall & (bit_cnt == 3'd7);
  wire [7:0] rx_byte = {shin[6:0], mosi};
  wire wr_fire = byte_done & have_addr & wr_mode & (~wp_frame | (addr == CTRL_A));

  assign miso    = cs & shout[7];
  assign miso_oe = cs;

  // time advance
  logic c_sec, c_min, c_hr, c_date, c_mon, leap;
  logic [7:0] hr_n, dim;
  wire [4:0] hr12_inc = (tm[2][3:0] == 4'h9) ? 5'h10 : tm[2][4:0] + 5'h01;

  always_comb begin
    leap = tm[6][4] ? (tm[6][3:0] == 4'h2 || tm[6][3:0] == 4'h6)
                    : (tm[6][3:0] == 4'h0 || tm[6][3:0] == 4'h4 || tm[6][3:0] == 4'h8);
    case (tm[5])
      8'h02:                      dim = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: dim = 8'h30;
      default:                    dim = 8'h31;
    endcase
    c_sec = tm[0] >= 8'h59;
    c_min = c_sec & (tm[1] >= 8'h59);
    if (!tm[2][6]) begin
      c_hr = c_min & (tm[2][5:0] >= 6'h23);
      hr_n = (tm[2][5:0] >= 6'h23) ? {tm[2][7:6], 6'h00} : bcd_inc(tm[2]);
    end else if (tm[2][4:0] == 5'h12) begin
      c_hr = 1'b0;
      hr_n = {tm[2][7:5], 5'h01};
    end else if (tm[2][4:0] == 5'h11) begin
      c_hr = c_min & tm[2][5];
      hr_n = {tm[2][7:6], ~tm[2][5], 5'h12};
    end else begin
      c_hr = 1'b0;
      hr_n = {tm[2][7:5], hr12_inc};
    end
    c_date = c_hr & (tm[4] >= dim);
    c_mon  = c_date & (tm[5] >= 8'h12);

    tm_n = tm;
    if (tick) begin
      tm_n[0] = c_sec ? 8'h00 : bcd_inc(tm[0]);
      if (c_sec) tm_n[1] = (tm[1] >= 8'h59) ? 8'h00 : bcd_inc(tm[1]);
      if (c_min) tm_n[2] = hr_n;
      if (c_hr) begin
        tm_n[3] = (tm[3] >= 8'h07) ? 8'h01 : tm[3] + 8'h01;
        tm_n[4] = (tm[4] >= dim) ? 8'h01 : bcd_inc(tm[4]);
      end
      if (c_date) tm_n[5] = (tm[5] >= 8'h12) ? 8'h01 : bcd_inc(tm[5]);
      if (c_mon)  tm_n[6] = (tm[6] >= 8'h99) ? 8'h00 : bcd_inc(tm[6]);
    end
    if (wr_fire && addr < 7'd7) tm_n[addr[2:0]] = rx_byte;
  end

  // read mux
  always_comb begin
    rd = 8'h00;
    if (addr < 7'd7)                      rd = snap[addr[2:0]];
    else if (addr < CTRL_A)               rd = alm[3'(addr - 7'd7)];
    else if (addr == CTRL_A)              rd = ctrl;
    else if (addr == TRK_A)               rd = trk;
    else if (addr >= RAM_A && addr < RAM_E) rd = ram[RAM_AW'(addr - RAM_A)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0; sck_q <= 1'b0;
      have_addr <= 1'b0; wr_mode <= 1'b0; wp_frame <= 1'b1;
      bit_cnt <= '0; addr <= '0; shin <= '0; shout <= '0;
      tm   <= {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
      snap <= '0;
      alm <= '0; ram <= '0; ctrl <= 8'h40; trk <= 8'h00;
    end else begin
      cs_q  <= cs;
      sck_q <= sck;
      tm    <= tm_n;
      if (!cs || frame_start) begin
        have_addr <= 1'b0; wr_mode <= 1'b0; bit_cnt <= '0;
        shin <= '0; shout <= '0;
        if (frame_start) begin
          snap     <= tm;
          wp_frame <= ctrl[6];
        end
      end else begin
        if (sck_rise) shout <= (bit_cnt == 3'd0 && have_addr) ? rd : {shout[6:0], 1'b0};
        if (sck_fall) begin
          shin    <= rx_byte;
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (byte_done) begin
          if (!have_addr) begin
            have_addr <= 1'b1;
            wr_mode   <= rx_byte[7];
            addr      <= rx_byte[6:0];
          end else begin
            addr <= addr + 7'd1;
          end
        end
      end
      if (wr_fire) begin
        if (addr >= 7'd7 && addr < CTRL_A) alm[3'(addr - 7'd7)] <= rx_byte;
        if (addr == CTRL_A) ctrl <= rx_byte;
        if (addr == TRK_A)  trk  <= rx_byte;
        if (addr >= RAM_A && addr < RAM_E) ram[RAM_AW'(addr - RAM_A)] <= rx_byte;
      end
    end
  end

  wire unused_ok = &{1'b0, STAT_A};
endmodule

// File: rtl/spi_rtc_regfile_chk.sv
module spi_rtc_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       cs_q,
  input logic       tick,
  input logic       miso,
  input logic       miso_oe,
  input logic       byte_done,
  input logic       have_addr,
  input logic       wr_mode,
  input logic       wp_frame,
  input logic [6:0] addr,
  input logic [2:0] bit_cnt,
  input logic [7:0] sec,
  input logic [7:0] trk,
  input logic [55:0] snap
);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> (!miso && !miso_oe));

  // R2
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (bit_cnt == 3'd0 && !have_addr));

  // R1
  addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && cs_q && byte_done && !have_addr) |=> have_addr);

  // R4
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && cs_q && byte_done && have_addr && wr_mode && wp_frame && addr == 7'h11) |=> $stable(trk));

  // R5
  wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && cs_q) |=> $stable(wp_frame));

  // R10
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && cs_q) |=> $stable(snap));

  // R6
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sec == 8'h59 && !(byte_done && have_addr && wr_mode && addr == 7'h00)) |=> sec == 8'h00);
endmodule

bind spi_rtc_regfile spi_rtc_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .cs_q(cs_q), .tick(tick),
  .miso(miso), .miso_oe(miso_oe), .byte_done(byte_done),
  .have_addr(have_addr), .wr_mode(wr_mode), .wp_frame(wp_frame),
  .addr(addr), .bit_cnt(bit_cnt), .sec(tm[0]), .trk(trk), .snap(snap)
);

// File: tb/tb_spi_rtc_regfile.sv
module tb_spi_rtc_regfile;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sck = 1'b0, mosi = 1'b0, tick = 1'b0;
  logic miso, miso_oe;
  int n_chk = 0, n_fail = 0;
  logic [7:0] wbuf [0:8];
  logic [7:0] rbuf [0:8];

  always #(CLK_P/2) clk = ~clk;

  spi_rtc_regfile dut (.clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .mosi(mosi),
                       .tick(tick), .miso(miso), .miso_oe(miso_oe));

  task automatic expect8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sck = 1'b1; mosi = tx[i];
      repeat (3) @(negedge clk);
      rx[i] = miso;
      @(negedge clk); sck = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic fbegin;
    @(negedge clk); cs = 1'b1; repeat (2) @(negedge clk);
  endtask

  task automatic fend;
    repeat (2) @(negedge clk); cs = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic wr_regs(input logic [6:0] a, input int n);
    logic [7:0] d;
    fbegin; xfer({1'b1, a}, d);
    for (int k = 0; k < n; k++) xfer(wbuf[k], d);
    fend;
  endtask

  task automatic rd_regs(input logic [6:0] a, input int n);
    logic [7:0] d;
    fbegin; xfer({1'b0, a}, d);
    for (int k = 0; k < n; k++) xfer(8'h00, rbuf[k]);
    fend;
  endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] v);
    wbuf[0] = v; wr_regs(a, 1);
  endtask

  task automatic rd1(input logic [6:0] a, output logic [7:0] v);
    rd_regs(a, 1); v = rbuf[0];
  endtask

  task automatic pulse_tick;
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
  endtask

  task automatic set_time(input logic [55:0] t);
    for (int k = 0; k < 7; k++) wbuf[k] = t[8*k +: 8];
    wr_regs(7'h00, 7);
  endtask

  task automatic expect_time(input string tag, input logic [55:0] t);
    rd_regs(7'h00, 7);
    for (int k = 0; k < 7; k++) expect8(tag, rbuf[k], t[8*k +: 8]);
  endtask

  // time vectors packed {year, month, date, weekday, hours, minutes, seconds}
  task automatic t_reset;
    logic [7:0] v;
    expect8("R12 miso idle", miso, 1'b0);
    expect8("R12 oe idle", miso_oe, 1'b0);
    expect_time("R13 reset time", {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00});
    rd1(7'h0F, v); expect8("R13 reset ctrl", v, 8'h40);
    rd1(7'h11, v); expect8("R13 reset trickle", v, 8'h00);
  endtask

  task automatic t_protect;
    logic [7:0] v;
    wr1(7'h00, 8'h33); rd1(7'h00, v); expect8("R4 protected seconds", v, 8'h00);
    wr1(7'h07, 8'h44); rd1(7'h07, v); expect8("R4 protected alarm", v, 8'h00);
    wbuf[0] = 8'h00; wbuf[1] = 8'h99; wbuf[2] = 8'hA5;
    wr_regs(7'h0F, 3);
    rd1(7'h0F, v); expect8("R4 control writable", v, 8'h00);
    rd1(7'h11, v); expect8("R5 same-frame still protected", v, 8'h00);
    wr1(7'h11, 8'hA5); rd1(7'h11, v); expect8("R5 next frame unlocked", v, 8'hA5);
  endtask

  task automatic t_map;
    logic [7:0] v;
    set_time({8'h24, 8'h06, 8'h15, 8'h03, 8'h12, 8'h30, 8'h45});
    expect_time("R2 burst time", {8'h24, 8'h06, 8'h15, 8'h03, 8'h12, 8'h30, 8'h45});
    for (int k = 0; k < 8; k++) wbuf[k] = 8'h11 + 8'(k);
    wr_regs(7'h07, 8);
    rd_regs(7'h07, 9);
    for (int k = 0; k < 8; k++) expect8("R3 alarm burst", rbuf[k], 8'h11 + 8'(k));
    expect8("R2 burst into control", rbuf[8], 8'h00);
    wr1(7'h10, 8'hFF); rd1(7'h10, v); expect8("R3 status reads zero", v, 8'h00);
    fbegin; xfer(8'h00, v); xfer(8'hFF, v); xfer(8'hFF, v); fend;
    rd_regs(7'h00, 2);
    expect8("R1 read frame no write sec", rbuf[0], 8'h45);
    expect8("R1 read frame no write min", rbuf[1], 8'h30);
  endtask

  task automatic t_window;
    logic [7:0] v;
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3;
    wr_regs(7'h20, 3); rd_regs(7'h20, 3);
    expect8("R11 ram 0", rbuf[0], 8'hC1);
    expect8("R11 ram 1", rbuf[1], 8'hC2);
    expect8("R11 ram 2", rbuf[2], 8'hC3);
    wr1(7'h28, 8'h5A); rd1(7'h28, v); expect8("R11 past ram", v, 8'h00);
    wr1(7'h15, 8'h77); rd1(7'h15, v); expect8("R11 gap address", v, 8'h00);
  endtask

  task automatic roll(input string tag, input logic [55:0] a, input logic [55:0] b);
    set_time(a); pulse_tick; expect_time(tag, b);
  endtask

  task automatic t_rollover;
    roll("R6 bcd seconds", {8'h10, 8'h05, 8'h10, 8'h01, 8'h05, 8'h00, 8'h09},
                          {8'h10, 8'h05, 8'h10, 8'h01, 8'h05, 8'h00, 8'h10});
    roll("R9 leap feb", {8'h24, 8'h02, 8'h28, 8'h06, 8'h23, 8'h59, 8'h59},
                       {8'h24, 8'h02, 8'h29, 8'h07, 8'h00, 8'h00, 8'h00});
    roll("R7 R9 plain feb", {8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59},
                           {8'h23, 8'h03, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00});
    roll("R9 year wrap", {8'h99, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59},
                        {8'h00, 8'h01, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00});
    roll("R9 thirty days", {8'h10, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59},
                          {8'h10, 8'h05, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00});
    roll("R8 11am to 12pm", {8'h10, 8'h05, 8'h10, 8'h01, 8'h51, 8'h59, 8'h59},
                           {8'h10, 8'h05, 8'h10, 8'h01, 8'h72, 8'h00, 8'h00});
    roll("R8 12pm to 1pm", {8'h10, 8'h05, 8'h10, 8'h01, 8'h72, 8'h59, 8'h59},
                          {8'h10, 8'h05, 8'h10, 8'h01, 8'h61, 8'h00, 8'h00});
    roll("R8 11pm to 12am", {8'h10, 8'h05, 8'h10, 8'h01, 8'h71, 8'h59, 8'h59},
                           {8'h10, 8'h05, 8'h11, 8'h02, 8'h52, 8'h00, 8'h00});
    roll("R8 12am to 1am", {8'h10, 8'h05, 8'h10, 8'h01, 8'h52, 8'h59, 8'h59},
                          {8'h10, 8'h05, 8'h10, 8'h01, 8'h41, 8'h00, 8'h00});
  endtask

  task automatic t_snapshot;
    logic [7:0] v;
    set_time({8'h00, 8'h01, 8'h01, 8'h01, 8'h05, 8'h00, 8'h59});
    fbegin; xfer(8'h00, v);
    xfer(8'h00, v); expect8("R10 snapshot sec", v, 8'h59);
    pulse_tick;
    xfer(8'h00, v); expect8("R10 snapshot min", v, 8'h00);
    fend;
    rd_regs(7'h00, 2);
    expect8("R10 new frame sec", rbuf[0], 8'h00);
    expect8("R10 new frame min", rbuf[1], 8'h01);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_protect;
    t_map;
    t_window;
    t_rollover;
    t_snapshot;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule